// File: doc/BRIEF.md
# Two-Bank SDRAM Command Front End

This block sits at the input of a two-bank synchronous DRAM behavioural model. On every rising clock edge it samples the chip-select, row-strobe, column-strobe and write-enable pins, the 12-bit address and the clock-enable pin. From these it works out which command was issued. It tracks whether each bank holds an open row and which row that is. It resolves which bank or banks a precharge or an auto-precharge applies to. It also counts down the clocks between an auto-precharging access and the moment the bank actually closes.

The decoded operation is registered and handed to a datapath one clock after the sampling edge. It carries the operation code, a bank mask, the open row, the column and the auto-precharge flag. A command that breaks the bank rules produces a one-cycle error pulse instead, and it leaves the bank state alone. The model's burst length and write-recovery time are parameters. The memory array and the burst address generator sit outside this block. Power-down and clock suspend also sit outside it, so clock-enable has an effect here only on refresh and on the self-refresh state.

Top module: `sdr_cmd_front`

## Requirements
- R1: After a synchronous active-low reset, both banks are closed, `op_valid`, `cmd_err` and `self_refresh` are 0, and `op_code` is 0.
- R2: An edge with `cs_n` high produces no operation and no error and changes no bank state. A running auto-precharge countdown keeps counting through such edges.
- R3: With `cs_n` low, the pins {ras_n,cas_n,we_n} decode as follows. 011 is activate (`op_code` 1), 101 is read (2), 100 is write (3), 010 is precharge (4), 110 is burst stop (5), 001 is refresh (6, or 7 for self-refresh entry) and 000 is mode set (8). The result appears on the outputs one clock after the sampling edge. 111 is no-operation and gives `op_valid` 0.
- R4: An activate opens the bank named by address bit 11 (0 selects bank 0, 1 selects bank 1) and stores address bits 10..0 as that bank's row. A later read or write to that bank reports the stored row on `op_row`.
- R5: A read or write reports address bits 9..0 on `op_col` and address bit 10 on `op_autopre`. Its `op_mask` is one-hot on the bank named by address bit 11.
- R6: A precharge with address bit 10 high closes both banks, whatever bit 11 is. With bit 10 low it closes only the bank named by bit 11. `op_mask` shows the banks closed.
- R7: A read with auto-precharge closes its bank on the BURST_LEN-th clock edge after the command edge.
- R8: A write with auto-precharge closes its bank on clock edge BURST_LEN-1+WR_RECOV after the command edge. That is WR_RECOV edges after the last data-in edge.
- R9: The following commands raise `cmd_err` for one cycle, give `op_valid` 0 and change no bank state: a read or write to a closed bank, a read or write to a bank with a pending auto-precharge, and an activate to an open bank.
- R10: Mode set and refresh are accepted only while both banks are closed, including banks still counting down. Otherwise they raise `cmd_err`.
- R11: A refresh sampled with `cke` low is self-refresh entry (`op_code` 7) and sets `self_refresh`. Every command is ignored until an edge samples `cke` high. That edge clears `self_refresh`, and its own command is also ignored.
- R12: A precharge that covers a bank with a pending auto-precharge closes it at once and cancels the countdown.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cke | input | 1 | Clock enable; selects self-refresh on refresh and ends self-refresh |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 12 | Address; bit 11 bank select, bit 10 precharge/auto-precharge qualifier |
| op_valid | output | 1 | An accepted operation is presented this cycle |
| op_code | output | 4 | Operation code (see R3) |
| op_mask | output | 2 | Banks affected by the operation |
| op_row | output | 11 | Row of an activate, or open row of the accessed bank |
| op_col | output | 10 | Column of a read or write |
| op_autopre | output | 1 | Read or write carries auto-precharge |
| cmd_err | output | 1 | One-cycle pulse for an illegal command |
| bank_open | output | 2 | Per-bank open state after the last edge |
| self_refresh | output | 1 | Self-refresh state is active |

## Verification
The bench targets the countdown boundaries. It issues a new access to a bank one edge before it closes, then again after it closes. A tracker with an off-by-one countdown would either accept that access or reject the next activate. Precharge is driven with bit 10 high and bit 11 set either way. A design that let bit 11 take priority would leave one bank open. Mode set and refresh are tried while one bank is mid-countdown. A design that looked only at the open flags, and not at the counters, would behave the same here, because a counting bank is still open. The bench also issues commands with chip select high during a countdown, and commands during self-refresh, including the exit edge. A decoder that let those commands through would show a spurious operation or a shifted close.

// File: rtl/sdr_cmd_pkg.sv
package sdr_cmd_pkg;

    localparam int NUM_BANKS = 2;

    typedef enum logic [3:0] {
        OP_NONE = 4'd0,
        OP_ACT  = 4'd1,
        OP_RD   = 4'd2,
        OP_WR   = 4'd3,
        OP_PRE  = 4'd4,
        OP_BST  = 4'd5,
        OP_REF  = 4'd6,
        OP_SREF = 4'd7,
        OP_MRS  = 4'd8
    } op_e;

    typedef enum logic [3:0] {
        K_IGN,
        K_NOP,
        K_ACT,
        K_RD,
        K_WR,
        K_PRE,
        K_BST,
        K_REF,
        K_MRS
    } kind_e;

endpackage

// File: rtl/sdr_cmd_decode.sv
module sdr_cmd_decode
    import sdr_cmd_pkg::*;
(
    input  logic  cs_n,
    input  logic  ras_n,
    input  logic  cas_n,
    input  logic  we_n,
    output kind_e kind
);

    always_comb begin
        kind = K_NOP;
        if (cs_n) begin
            kind = K_IGN;
        end else begin
            unique case ({ras_n, cas_n, we_n})
                3'b011: kind = K_ACT;
                3'b101: kind = K_RD;
                3'b100: kind = K_WR;
                3'b010: kind = K_PRE;
                3'b110: kind = K_BST;
                3'b001: kind = K_REF;
                3'b000: kind = K_MRS;
                default: kind = K_NOP;
            endcase
        end
    end

endmodule

// File: rtl/sdr_bank_track.sv
module sdr_bank_track #(
    parameter int ROW_W = 11,
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             open_i,
    input  logic [ROW_W-1:0] row_i,
    input  logic             close_i,
    input  logic             arm_i,
    input  logic [CNT_W-1:0] delay_i,
    output logic             open_o,
    output logic             closing_o,
    output logic [ROW_W-1:0] row_o
);

    typedef struct packed {
        logic             open;
        logic [ROW_W-1:0] row;
        logic [CNT_W-1:0] cnt;
    } bank_t;

    bank_t s_q, s_d;

    always_comb begin
        s_d = s_q;
        if (close_i) begin
            s_d.open = 1'b0;
            s_d.cnt  = '0;
        end else if (open_i) begin
            s_d.open = 1'b1;
            s_d.row  = row_i;
            s_d.cnt  = '0;
        end else if (arm_i) begin
            s_d.cnt = delay_i;
        end else if (s_q.cnt != '0) begin
            s_d.cnt = s_q.cnt - 1'b1;
            if (s_q.cnt == CNT_W'(1)) begin
                s_d.open = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign open_o    = s_q.open;
    assign closing_o = (s_q.cnt != '0);
    assign row_o     = s_q.row;

    // A countdown only runs on an open bank (R7, R8)
    assert_closing_needs_open_R7: assert property (@(posedge clk) disable iff (!rst_n)
        closing_o |-> open_o);

    // Arming starts a countdown on the next cycle (R8)
    assert_arm_starts_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_i && !close_i && !open_i && delay_i != '0) |=> closing_o);

    // Activate opens the bank and holds its row (R4)
    assert_open_keeps_row_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (open_i && !close_i) |=> (open_o && row_o == $past(row_i)));

    // Precharge closes immediately (R12)
    assert_close_now_R12: assert property (@(posedge clk) disable iff (!rst_n)
        close_i |=> (!open_o && !closing_o));

endmodule

// File: rtl/sdr_cmd_front.sv
module sdr_cmd_front
    import sdr_cmd_pkg::*;
#(
    parameter int ROW_W     = 11,
    parameter int COL_W     = 10,
    parameter int BURST_LEN = 4,
    parameter int WR_RECOV  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cke,
    input  logic             cs_n,
    input  logic             ras_n,
    input  logic             cas_n,
    input  logic             we_n,
    input  logic [ROW_W:0]   addr,
    output logic             op_valid,
    output logic [3:0]       op_code,
    output logic [1:0]       op_mask,
    output logic [ROW_W-1:0] op_row,
    output logic [COL_W-1:0] op_col,
    output logic             op_autopre,
    output logic             cmd_err,
    output logic [1:0]       bank_open,
    output logic             self_refresh
);

    localparam int BANK_BIT = ROW_W;
    localparam int AP_BIT   = ROW_W - 1;
    localparam int RD_DLY   = BURST_LEN;
    localparam int WR_DLY   = BURST_LEN - 1 + WR_RECOV;
    localparam int MAX_DLY  = (RD_DLY > WR_DLY) ? RD_DLY : WR_DLY;
    localparam int CNT_W    = $clog2(MAX_DLY + 1);

    typedef struct packed {
        logic                 valid;
        op_e                  code;
        logic [NUM_BANKS-1:0] mask;
        logic [ROW_W-1:0]     row;
        logic [COL_W-1:0]     col;
        logic                 ap;
        logic                 err;
        logic                 sref;
    } out_t;

    out_t out_q, out_d;

    kind_e                kind;
    logic                 bsel;
    logic                 ap_bit;
    logic [NUM_BANKS-1:0] sel_mask;
    logic [NUM_BANKS-1:0] open_w;
    logic [NUM_BANKS-1:0] closing_w;
    logic [ROW_W-1:0]     row_w [NUM_BANKS];
    logic [NUM_BANKS-1:0] do_open, do_close, do_arm;
    logic [CNT_W-1:0]     arm_dly;

    sdr_cmd_decode u_dec (
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .kind  (kind)
    );

    assign bsel   = addr[BANK_BIT];
    assign ap_bit = addr[AP_BIT];

    always_comb begin
        sel_mask       = '0;
        sel_mask[bsel] = 1'b1;
    end

    always_comb begin
        out_d      = '0;
        out_d.code = OP_NONE;
        out_d.sref = out_q.sref;
        do_open    = '0;
        do_close   = '0;
        do_arm     = '0;
        arm_dly    = CNT_W'(RD_DLY);
        if (out_q.sref) begin
            if (cke) begin
                out_d.sref = 1'b0;
            end
        end else begin
            unique case (kind)
                K_ACT: begin
                    if (open_w[bsel]) begin
                        out_d.err = 1'b1;
                    end else begin
                        out_d.valid   = 1'b1;
                        out_d.code    = OP_ACT;
                        out_d.mask    = sel_mask;
                        out_d.row     = addr[ROW_W-1:0];
                        do_open[bsel] = 1'b1;
                    end
                end
                K_RD, K_WR: begin
                    if (!open_w[bsel] || closing_w[bsel]) begin
                        out_d.err = 1'b1;
                    end else begin
                        out_d.valid  = 1'b1;
                        out_d.code   = (kind == K_RD) ? OP_RD : OP_WR;
                        out_d.mask   = sel_mask;
                        out_d.row    = row_w[bsel];
                        out_d.col    = addr[COL_W-1:0];
                        out_d.ap     = ap_bit;
                        do_arm[bsel] = ap_bit;
                        arm_dly      = (kind == K_RD) ? CNT_W'(RD_DLY) : CNT_W'(WR_DLY);
                    end
                end
                K_PRE: begin
                    out_d.valid = 1'b1;
                    out_d.code  = OP_PRE;
                    out_d.mask  = ap_bit ? {NUM_BANKS{1'b1}} : sel_mask;
                    do_close    = out_d.mask;
                end
                K_BST: begin
                    out_d.valid = 1'b1;
                    out_d.code  = OP_BST;
                end
                K_REF: begin
                    if (open_w != '0) begin
                        out_d.err = 1'b1;
                    end else begin
                        out_d.valid = 1'b1;
                        out_d.code  = cke ? OP_REF : OP_SREF;
                        out_d.mask  = {NUM_BANKS{1'b1}};
                        out_d.sref  = !cke;
                    end
                end
                K_MRS: begin
                    if (open_w != '0) begin
                        out_d.err = 1'b1;
                    end else begin
                        out_d.valid = 1'b1;
                        out_d.code  = OP_MRS;
                    end
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q      <= '0;
            out_q.code <= OP_NONE;
        end else begin
            out_q <= out_d;
        end
    end

    for (genvar gb = 0; gb < NUM_BANKS; gb++) begin : g_bank
        sdr_bank_track #(
            .ROW_W (ROW_W),
            .CNT_W (CNT_W)
        ) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .open_i    (do_open[gb]),
            .row_i     (addr[ROW_W-1:0]),
            .close_i   (do_close[gb]),
            .arm_i     (do_arm[gb]),
            .delay_i   (arm_dly),
            .open_o    (open_w[gb]),
            .closing_o (closing_w[gb]),
            .row_o     (row_w[gb])
        );
    end

    assign op_valid     = out_q.valid;
    assign op_code      = out_q.code;
    assign op_mask      = out_q.mask;
    assign op_row       = out_q.row;
    assign op_col       = out_q.col;
    assign op_autopre   = out_q.ap;
    assign cmd_err      = out_q.err;
    assign bank_open    = open_w;
    assign self_refresh = out_q.sref;

    // Errors never coincide with a presented operation (R9)
    assert_err_excludes_op_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |-> !op_valid);

    // An error leaves the bank state untouched when no countdown was running (R9)
    assert_err_keeps_state_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_err && $past(closing_w) == '0) |-> bank_open == $past(bank_open));

    // Deselected edges produce nothing (R2)
    assert_cs_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cs_n) |-> (!op_valid && !cmd_err));

    // Mode set and refresh only on an idle device (R10)
    assert_idle_for_global_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_code == OP_MRS || op_code == OP_REF || op_code == OP_SREF))
            |-> $past(bank_open) == '0);

    // Activate names one bank and leaves it open (R4)
    assert_act_opens_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_ACT) |-> ($onehot(op_mask) && (bank_open & op_mask) != '0));

    // Precharge leaves every named bank closed (R6)
    assert_pre_closes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_PRE) |-> (bank_open & op_mask) == '0);

    // Nothing is accepted while self-refresh persists (R11)
    assert_sref_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (self_refresh && $past(self_refresh)) |-> (!op_valid && !cmd_err));

endmodule

// File: tb/sim_sdr_cmd_front.sv
module sim_sdr_cmd_front;

    localparam int BL  = 4;
    localparam int WRR = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cke = 1'b1;
    logic        cs_n = 1'b1;
    logic        ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [11:0] addr = '0;
    logic        op_valid, op_autopre, cmd_err, self_refresh;
    logic [3:0]  op_code;
    logic [1:0]  op_mask, bank_open;
    logic [10:0] op_row;
    logic [9:0]  op_col;

    always #10 clk = ~clk;

    sdr_cmd_front #(.BURST_LEN(BL), .WR_RECOV(WRR)) u0 (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .addr(addr), .op_valid(op_valid),
        .op_code(op_code), .op_mask(op_mask), .op_row(op_row), .op_col(op_col),
        .op_autopre(op_autopre), .cmd_err(cmd_err), .bank_open(bank_open),
        .self_refresh(self_refresh)
    );

    typedef struct {
        string       tag;
        logic        valid;
        logic [3:0]  code;
        logic [1:0]  mask;
        logic [10:0] row;
        logic [9:0]  col;
        logic        ap;
        logic        err;
        logic [1:0]  open;
        logic        sref;
    } exp_t;

    exp_t q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done = 0;

    // Reference state built from the requirements
    logic        m_open [2];
    logic [10:0] m_row  [2];
    int          m_cnt  [2];
    logic        m_sref;

    localparam logic [2:0] C_ACT = 3'b011, C_RD = 3'b101, C_WR = 3'b100, C_PRE = 3'b010,
                           C_BST = 3'b110, C_REF = 3'b001, C_MRS = 3'b000, C_NOP = 3'b111;

    task automatic step(input string tag, input logic cs, input logic [2:0] rcw,
                        input logic [11:0] a, input logic ck);
        exp_t e;
        logic b;
        logic [1:0] pre_m, act_m, arm_m;
        int dly;
        b = a[11];
        pre_m = '0; act_m = '0; arm_m = '0; dly = 0;
        e.tag = tag; e.valid = 0; e.code = 0; e.mask = 0; e.row = 0; e.col = 0;
        e.ap = 0; e.err = 0;
        if (m_sref) begin
            if (ck) m_sref = 0;
        end else if (!cs) begin
            case (rcw)
                C_ACT: if (m_open[b]) e.err = 1;
                       else begin e.valid = 1; e.code = 1; e.mask = 2'b01 << b;
                                  e.row = a[10:0]; act_m[b] = 1; end
                C_RD, C_WR: if (!m_open[b] || m_cnt[b] != 0) e.err = 1;
                       else begin
                           e.valid = 1; e.code = (rcw == C_RD) ? 4'd2 : 4'd3;
                           e.mask = 2'b01 << b; e.row = m_row[b]; e.col = a[9:0];
                           e.ap = a[10]; arm_m[b] = a[10];
                           dly = (rcw == C_RD) ? BL : BL - 1 + WRR;
                       end
                C_PRE: begin e.valid = 1; e.code = 4; e.mask = a[10] ? 2'b11 : (2'b01 << b);
                             pre_m = e.mask; end
                C_BST: begin e.valid = 1; e.code = 5; end
                C_REF: if (m_open[0] || m_open[1]) e.err = 1;
                       else begin e.valid = 1; e.code = ck ? 4'd6 : 4'd7; e.mask = 2'b11;
                                  if (!ck) m_sref = 1; end
                C_MRS: if (m_open[0] || m_open[1]) e.err = 1;
                       else begin e.valid = 1; e.code = 8; end
                default: ;
            endcase
        end
        for (int i = 0; i < 2; i++) begin
            if (pre_m[i]) begin m_open[i] = 0; m_cnt[i] = 0; end
            else if (act_m[i]) begin m_open[i] = 1; m_row[i] = a[10:0]; m_cnt[i] = 0; end
            else if (arm_m[i]) m_cnt[i] = dly;
            else if (m_cnt[i] > 0) begin
                m_cnt[i]--;
                if (m_cnt[i] == 0) m_open[i] = 0;
            end
        end
        e.open = {m_open[1], m_open[0]};
        e.sref = m_sref;
        @(negedge clk);
        cs_n = cs; {ras_n, cas_n, we_n} = rcw; addr = a; cke = ck;
        q.push_back(e);
    endtask

    task automatic nop(input string tag, input int n);
        for (int i = 0; i < n; i++) step(tag, 1'b0, C_NOP, 12'h000, 1'b1);
    endtask

    // Monitor: compare after each edge, away from it
    always @(posedge clk) begin
        #2;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_cmp++;
            if (op_valid !== e.valid || op_code !== e.code || op_mask !== e.mask ||
                op_row !== e.row || op_col !== e.col || op_autopre !== e.ap ||
                cmd_err !== e.err || bank_open !== e.open || self_refresh !== e.sref) begin
                n_bad++;
                $display("FAIL %s: got v%b c%0d m%b r%h k%h a%b e%b o%b s%b exp v%b c%0d m%b r%h k%h a%b e%b o%b s%b",
                    e.tag, op_valid, op_code, op_mask, op_row, op_col, op_autopre, cmd_err,
                    bank_open, self_refresh, e.valid, e.code, e.mask, e.row, e.col, e.ap,
                    e.err, e.open, e.sref);
            end
        end
    end

    initial begin
        #(20 * 5000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got hang exp completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 2; i++) begin m_open[i] = 0; m_row[i] = 0; m_cnt[i] = 0; end
        m_sref = 0;
        repeat (3) @(negedge clk);
        cs_n = 1'b0; {ras_n, cas_n, we_n} = C_ACT; addr = 12'h0AB;
        @(negedge clk);
        rst_n = 1'b1; cs_n = 1'b1;
        // R1: reset state, reset-time activate must not have opened anything
        nop("R1", 1);
        step("R10", 1'b0, C_MRS, 12'h032, 1'b1);
        step("R10", 1'b0, C_REF, 12'h000, 1'b1);
        // R3/R4: activates on both banks
        step("R4", 1'b0, C_ACT, 12'h123, 1'b1);
        step("R4", 1'b0, C_ACT, 12'hC56, 1'b1);
        step("R9", 1'b0, C_ACT, 12'h001, 1'b1);
        step("R5", 1'b0, C_RD, 12'h005, 1'b1);
        step("R5", 1'b0, C_WR, 12'h9FF, 1'b1);
        step("R10", 1'b0, C_MRS, 12'h000, 1'b1);
        step("R10", 1'b0, C_REF, 12'h000, 1'b1);
        step("R2", 1'b1, C_ACT, 12'h800, 1'b1);
        step("R2", 1'b1, C_PRE, 12'h400, 1'b1);
        step("R3", 1'b0, C_BST, 12'h000, 1'b1);
        nop("R3", 1);
        // R6: single-bank precharge of bank 1
        step("R6", 1'b0, C_PRE, 12'h800, 1'b1);
        step("R9", 1'b0, C_RD, 12'h800, 1'b1);
        step("R9", 1'b0, C_WR, 12'h800, 1'b1);
        // R7: read with auto-precharge on bank 0
        step("R7", 1'b0, C_RD, 12'h407, 1'b1);
        step("R9", 1'b0, C_RD, 12'h001, 1'b1);
        step("R9", 1'b0, C_ACT, 12'h010, 1'b1);
        step("R10", 1'b0, C_REF, 12'h000, 1'b1);
        nop("R7", 1);
        step("R7", 1'b0, C_ACT, 12'h0EE, 1'b1);
        // R8: write with auto-precharge on bank 1, countdown through deselects
        step("R8", 1'b0, C_ACT, 12'h8AA, 1'b1);
        step("R8", 1'b0, C_WR, 12'hC21, 1'b1);
        step("R2", 1'b1, C_RD, 12'h800, 1'b1);
        step("R2", 1'b1, C_NOP, 12'h000, 1'b1);
        nop("R8", 1);
        step("R9", 1'b0, C_ACT, 12'h801, 1'b1);
        nop("R8", 2);
        step("R8", 1'b0, C_ACT, 12'h802, 1'b1);
        // R12: all-bank precharge cancels a pending countdown, bit 11 set
        step("R12", 1'b0, C_RD, 12'h400, 1'b1);
        step("R12", 1'b0, C_PRE, 12'hC00, 1'b1);
        nop("R12", 5);
        step("R6", 1'b0, C_ACT, 12'h811, 1'b1);
        step("R6", 1'b0, C_ACT, 12'h022, 1'b1);
        step("R6", 1'b0, C_PRE, 12'h400, 1'b1);
        // R11: self-refresh entry, ignored commands, exit edge
        step("R11", 1'b0, C_REF, 12'h000, 1'b0);
        step("R11", 1'b0, C_ACT, 12'h033, 1'b0);
        step("R11", 1'b0, C_MRS, 12'h000, 1'b0);
        step("R11", 1'b0, C_ACT, 12'h044, 1'b1);
        step("R11", 1'b0, C_ACT, 12'h055, 1'b1);
        step("R3", 1'b0, C_REF, 12'h000, 1'b0);
        step("R3", 1'b0, C_NOP, 12'h000, 1'b1);
        step("R4", 1'b0, C_RD, 12'h003, 1'b1);
        nop("R1", 3);
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule